// File: doc/BRIEF.md
# Bit-Banged I2C Master Byte Engine

This block drives an open-drain two-wire bus as a master, one host command at a time. The host can ask for a bus start condition, a stop condition, an eight-bit write with acknowledge sampling, or an eight-bit read that ends with an acknowledge bit the host chooses. Every bus phase lasts a whole number of microseconds, either a short (3 us) or a long (6 us) step. A local prescaler, restarted at each phase boundary, counts those microseconds. The engine releases a line by letting the pull-up take it high. Each time it does so it reads the line back through a two-flop synchronizer. It latches the first fault it sees into a sticky 3-bit code that only a dedicated clear strobe resets.

The sequencer is a single state machine. `S_IDLE` accepts a command. Start runs `S_C_SDAH` (release data, 3 us) → `S_C_SCLH` (release clock, 3 us, check clock) → `S_C_HOLD` (6 us) → `S_C_SDAL` (pull data low, 6 us) → `S_C_SCLL` (pull clock low, 6 us) → `S_IDLE`. Stop runs `S_P_SDAL` (pull data low, 3 us) → `S_P_SCLH` (release clock, 3 us, check clock) → `S_P_HOLD` (6 us) → `S_P_SDAH` (release data, 3 us, check data) → `S_P_TAIL` (3 us) → `S_IDLE`. A byte runs nine bit slots. Each slot goes `S_B_SDA` (set data: 3 us then check data when releasing it for a transmitted one, otherwise 6 us) → optional `S_B_SDAX` (6 us, only after that check) → `S_B_SCLH` (release clock, 3 us, check clock) → `S_B_HIGH` (6 us when transmitting, 3 us when receiving, then sample) → `S_B_SCLL` (pull clock low, 6 us). From `S_B_SCLL` the machine returns to `S_B_SDA` for the next slot, or to `S_IDLE` after the ninth.

Top module: `i2c_byte_master`

## Requirements
- R1: Command code 00 (start) releases data, then clock, then pulls data low while the clock is still released, then pulls the clock low. It finishes with both lines pulled low and exactly one start condition seen on the bus.
- R2: Command code 01 (stop) pulls data low, releases the clock, then releases data while the clock is released. It finishes with both lines released and exactly one stop condition seen on the bus.
- R3: Command code 10 (write) shifts `wr_data` onto the bus most significant bit first, one bit per clock pulse. It then releases data for a ninth pulse and returns the level sampled there on `ack_out` (0 = acknowledged).
- R4: Command code 11 (read) samples eight bits, shifting each into the least significant end, and presents them on `rd_data`. On the ninth pulse it drives the `ack_in` value captured at command time (0 pulls data low, 1 releases it).
- R5: With CLK_PER_US clocks per microsecond, the clock line stays released for exactly 9 us during a transmitted bit and 6 us during a received bit. No state changes before its phase timer runs out.
- R6: If the clock line reads low at the end of the 3 us check after the engine releases it, error code 1 is raised.
- R7: If data reads low 3 us after the engine releases it to send a one, error code 2 is raised.
- R8: A high level on the write acknowledge pulse raises error code 3.
- R9: If data reads low 3 us after the engine releases it during stop, error code 4 is raised.
- R10: `err_code` holds the first nonzero code after reset or a clear. Later faults and later commands leave it unchanged, and a one-cycle `err_clr` pulse returns it to 0.
- R11: `busy` is high from the cycle after a command is accepted until it finishes. Commands offered while busy are dropped without effect.
- R12: `done` pulses high for exactly one clock, with `busy` low, when each command finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd | input | 2 | 00 start, 01 stop, 10 write, 11 read |
| wr_data | input | 8 | Byte to write |
| ack_in | input | 1 | Acknowledge to send after a read |
| rd_data | output | 8 | Last byte read |
| ack_out | output | 1 | Acknowledge sampled after last write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_clr | input | 1 | Clears the sticky error code |
| err_code | output | 3 | Sticky first-fault code |
| scl_i | input | 1 | Clock line level from the pad |
| sda_i | input | 1 | Data line level from the pad |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The hardest condition to reach from the ports is a fault arriving after another fault has already latched. The engine never stops or retries, so the stimulus has to keep the bus broken through a whole command. The bench holds data low across a write of 0x80 and then across a stop. That raises code 2 first and then presents the code 4 condition, which must be ignored. Holding the clock low through a write of 0x00 likewise produces a clock fault followed by a floating acknowledge, and only the first of the two may be kept. A behavioural slave, counting falling clock edges on the shared bus, supplies acknowledges and read data. A bus monitor rebuilds each transferred bit and measures the clock-high widths.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    typedef enum logic [1:0] {
        CMD_START = 2'b00,
        CMD_STOP  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_READ  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_SCL_LOW  = 3'd1,
        ERR_SDA_LOW  = 3'd2,
        ERR_NACK     = 3'd3,
        ERR_STOP_SDA = 3'd4
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_C_SDAH, S_C_SCLH, S_C_HOLD, S_C_SDAL, S_C_SCLL,
        S_P_SDAL, S_P_SCLH, S_P_HOLD, S_P_SDAH, S_P_TAIL,
        S_B_SDA, S_B_SDAX, S_B_SCLH, S_B_HIGH, S_B_SCLL
    } state_e;

endpackage

// File: rtl/i2c_bm_us_tick.sv
module i2c_bm_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = $clog2(CLK_PER_US + 1);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pc_q;

    assign tick = (pc_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pc_q <= '0;
        else if (restart)    pc_q <= '0;
        else if (tick)       pc_q <= '0;
        else                 pc_q <= pc_q + PW'(1);
    end
endmodule

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
    parameter int        W       = 2,
    parameter logic      RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= {W{RST_VAL}};
            s2_q <= {W{RST_VAL}};
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/i2c_bm_err_reg.sv
module i2c_bm_err_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set,
    input  logic [2:0] code_in,
    output logic [2:0] code
);
    logic [2:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          code_q <= 3'd0;
        else if (clr)                        code_q <= 3'd0;
        else if (set && code_q == 3'd0)      code_q <= code_in;
    end

    assign code = code_q;

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != 3'd0 && !clr) |=> code_q == $past(code_q));
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> code_q == 3'd0);
    assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= 3'd4);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int T_SHORT    = 3,
    parameter int T_LONG     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic [7:0] wr_data,
    input  logic       ack_in,
    output logic [7:0] rd_data,
    output logic       ack_out,
    output logic       busy,
    output logic       done,
    input  logic       err_clr,
    output logic [2:0] err_code,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int TW = $clog2(T_LONG + 1);
    localparam int NBITS = 9;
    localparam int IW = $clog2(NBITS + 1);
    localparam logic [IW-1:0] ACK_IDX = IW'(NBITS - 1);
    localparam logic [IW-1:0] END_IDX = IW'(NBITS);

    state_e          state_q, state_d;
    logic [TW-1:0]   tmr_q, dur_d;
    logic            tick, expire, adv, accept;
    logic            scl_s, sda_s;
    logic            scl_low_q, sda_low_q;
    logic [7:0]      sh_q;
    logic [IW-1:0]   idx_q;
    logic            rd_op_q, ack_hold_q;
    logic            cur_rx, cur_bit, ent_rx, ent_bit;
    logic            err_set;
    err_e            err_val;

    i2c_bm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(adv), .tick(tick));

    i2c_bm_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

    i2c_bm_err_reg u_err (
        .clk(clk), .rst_n(rst_n), .clr(err_clr), .set(err_set),
        .code_in(err_val), .code(err_code));

    assign accept  = cmd_valid && (state_q == S_IDLE);
    assign expire  = tick && (tmr_q == '0);
    assign cur_rx  = rd_op_q ^ (idx_q == ACK_IDX);
    assign cur_bit = (idx_q == ACK_IDX) ? ack_hold_q : sh_q[7];
    assign ent_rx  = accept ? (cmd == CMD_READ) : cur_rx;
    assign ent_bit = accept ? wr_data[7] : cur_bit;
    assign adv     = (state_d != state_q);
    assign busy    = (state_q != S_IDLE);
    assign scl_oe  = scl_low_q;
    assign sda_oe  = sda_low_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (cmd_valid) begin
                    unique case (cmd)
                        CMD_START: state_d = S_C_SDAH;
                        CMD_STOP:  state_d = S_P_SDAL;
                        default:   state_d = S_B_SDA;
                    endcase
                end
            S_C_SDAH: if (expire) state_d = S_C_SCLH;
            S_C_SCLH: if (expire) state_d = S_C_HOLD;
            S_C_HOLD: if (expire) state_d = S_C_SDAL;
            S_C_SDAL: if (expire) state_d = S_C_SCLL;
            S_C_SCLL: if (expire) state_d = S_IDLE;
            S_P_SDAL: if (expire) state_d = S_P_SCLH;
            S_P_SCLH: if (expire) state_d = S_P_HOLD;
            S_P_HOLD: if (expire) state_d = S_P_SDAH;
            S_P_SDAH: if (expire) state_d = S_P_TAIL;
            S_P_TAIL: if (expire) state_d = S_IDLE;
            S_B_SDA:  if (expire) state_d = (!cur_rx && cur_bit) ? S_B_SDAX : S_B_SCLH;
            S_B_SDAX: if (expire) state_d = S_B_SCLH;
            S_B_SCLH: if (expire) state_d = S_B_HIGH;
            S_B_HIGH: if (expire) state_d = S_B_SCLL;
            S_B_SCLL: if (expire) state_d = (idx_q == END_IDX) ? S_IDLE : S_B_SDA;
        endcase
    end

    // phase length of the state being entered
    always_comb begin
        case (state_d)
            S_C_SDAH, S_C_SCLH, S_P_SDAL, S_P_SCLH,
            S_P_SDAH, S_P_TAIL, S_B_SCLH: dur_d = TW'(T_SHORT);
            S_B_SDA:  dur_d = (!ent_rx && ent_bit) ? TW'(T_SHORT) : TW'(T_LONG);
            S_B_HIGH: dur_d = cur_rx ? TW'(T_SHORT) : TW'(T_LONG);
            default:  dur_d = TW'(T_LONG);
        endcase
    end

    // readback checks at the end of a phase
    always_comb begin
        err_set = 1'b0;
        err_val = ERR_NONE;
        if (expire) begin
            case (state_q)
                S_C_SCLH, S_P_SCLH, S_B_SCLH:
                    if (!scl_s) begin err_set = 1'b1; err_val = ERR_SCL_LOW; end
                S_B_SDA:
                    if (!cur_rx && cur_bit && !sda_s) begin
                        err_set = 1'b1; err_val = ERR_SDA_LOW;
                    end
                S_P_SDAH:
                    if (!sda_s) begin err_set = 1'b1; err_val = ERR_STOP_SDA; end
                S_B_HIGH:
                    if (idx_q == ACK_IDX && !rd_op_q && sda_s) begin
                        err_set = 1'b1; err_val = ERR_NACK;
                    end
                default: ;
            endcase
        end
    end

    // state register and phase timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (adv)                      tmr_q <= dur_d - TW'(1);
            else if (tick && tmr_q != '0) tmr_q <= tmr_q - TW'(1);
        end
    end

    // line drives, shifter and host-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low_q  <= 1'b0;
            sda_low_q  <= 1'b0;
            sh_q       <= '0;
            idx_q      <= '0;
            rd_op_q    <= 1'b0;
            ack_hold_q <= 1'b0;
            rd_data    <= '0;
            ack_out    <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                rd_op_q    <= (cmd == CMD_READ);
                ack_hold_q <= ack_in;
                sh_q       <= wr_data;
                idx_q      <= '0;
            end
            if (adv) begin
                case (state_d)
                    S_C_SDAH, S_P_SDAH:           sda_low_q <= 1'b0;
                    S_C_SDAL, S_P_SDAL:           sda_low_q <= 1'b1;
                    S_C_SCLH, S_P_SCLH, S_B_SCLH: scl_low_q <= 1'b0;
                    S_C_SCLL, S_B_SCLL:           scl_low_q <= 1'b1;
                    S_B_SDA:                      sda_low_q <= !ent_rx && !ent_bit;
                    S_IDLE:                       done      <= 1'b1;
                    default: ;
                endcase
                if (state_d == S_IDLE && state_q == S_B_SCLL && rd_op_q)
                    rd_data <= sh_q;
            end
            if (expire && state_q == S_B_HIGH) begin
                idx_q <= idx_q + IW'(1);
                if (cur_rx) begin
                    if (idx_q == ACK_IDX) ack_out <= sda_s;
                    else                  sh_q    <= {sh_q[6:0], sda_s};
                end else if (idx_q != ACK_IDX) begin
                    sh_q <= {sh_q[6:0], 1'b0};
                end
            end
        end
    end

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_hold_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expire) |=> state_q == $past(state_q));
    assert_stop_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_low_q) && !scl_low_q) |-> (state_q == S_P_SDAH || state_q == S_C_SDAH));
    assert_start_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_C_SDAL && $past(state_q) == S_C_HOLD) |-> (sda_low_q && !scl_low_q));
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CPU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic ack_in = 1'b0;
    logic err_clr = 1'b0;
    logic [7:0] rd_data;
    logic ack_out, busy, done;
    logic [2:0] err_code;
    logic scl_oe, sda_oe;
    logic scl_bus, sda_bus;
    logic force_scl = 1'b0, force_sda = 1'b0;
    logic slave_low;
    int   smode = 0;
    logic slave_ack = 1'b1;
    logic [7:0] rbyte = 8'h00;

    int n_chk = 0, n_err = 0;
    int falls = 0, fall_base = 0, rel;
    int starts = 0, stops = 0, done_cnt = 0, cyc = 0;
    int hi_cnt = 0, last_hi = 0;
    logic scl_prev = 1'b1, sda_prev = 1'b1;
    logic [8:0] cap = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rel = falls - fall_base;
    assign slave_low = (smode == 1 && rel == 8 && slave_ack) ||
                       (smode == 2 && rel < 8 && !rbyte[(7 - rel) & 7]);
    assign scl_bus = !scl_oe && !force_scl;
    assign sda_bus = !sda_oe && !slave_low && !force_sda;

    i2c_byte_master #(.CLK_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_data(wr_data), .ack_in(ack_in), .rd_data(rd_data),
        .ack_out(ack_out), .busy(busy), .done(done), .err_clr(err_clr),
        .err_code(err_code), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe));

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // bus monitor and watchdog, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (scl_prev && !scl_bus) begin falls++; last_hi = hi_cnt; end
        if (scl_bus && !scl_prev) begin hi_cnt = 1; cap = {cap[7:0], sda_bus}; end
        else if (scl_bus) hi_cnt++;
        if (scl_bus && scl_prev && sda_prev && !sda_bus) starts++;
        if (scl_bus && scl_prev && !sda_prev && sda_bus) stops++;
        scl_prev = scl_bus;
        sda_prev = sda_bus;
        if (cyc > 190000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] c, input logic [7:0] d, input logic a);
        int d0;
        @(posedge clk); #1;
        fall_base = falls;
        d0 = done_cnt;
        cmd = c; wr_data = d; ack_in = a; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R11 busy after accept", int'(busy), 1);
        while (!done) @(negedge clk);
        chk("R12 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk("R12 done one cycle", int'(done), 0);
        chk("R12 one done per command", done_cnt - d0, 1);
    endtask

    task automatic clear_err();
        @(posedge clk); #1 err_clr = 1'b1;
        @(posedge clk); #1 err_clr = 1'b0;
        @(negedge clk);
        chk("R10 clear", int'(err_code), 0);
    endtask

    initial begin
        int s0, p0, d0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset done", int'(done), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R2 reset lines released", int'({scl_oe, sda_oe}), 0);
        chk("R10 reset err", int'(err_code), 0);

        // R1 start
        s0 = starts;
        run_cmd(2'b00, 8'h00, 1'b0);
        chk("R1 one start seen", starts - s0, 1);
        chk("R1 both lines pulled", int'({scl_oe, sda_oe}), 3);

        // R3 write sweep
        smode = 1; slave_ack = 1'b1;
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            b = 8'((i * 37 + 5) & 255);
            run_cmd(2'b10, b, 1'b0);
            chk("R3 byte on bus MSB first", int'(cap[8:1]), int'(b));
            chk("R3 ack returned", int'(ack_out), 0);
        end
        chk("R5 clock high in received bit", last_hi, 6 * CPU);
        chk("R10 no fault after writes", int'(err_code), 0);

        // R4 read sweep
        smode = 2;
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            logic a;
            b = 8'((i * 53 + 11) & 255);
            a = 1'(i & 1);
            rbyte = b;
            run_cmd(2'b11, 8'h00, a);
            chk("R4 read byte", int'(rd_data), int'(b));
            chk("R4 master ack bit on bus", int'(cap[0]), int'(a));
        end
        chk("R5 clock high in transmitted bit", last_hi, 9 * CPU);
        chk("R10 no fault after reads", int'(err_code), 0);

        // R2 stop
        smode = 0;
        p0 = stops;
        run_cmd(2'b01, 8'h00, 1'b0);
        chk("R2 one stop seen", stops - p0, 1);
        chk("R2 both lines released", int'({scl_oe, sda_oe}), 0);

        // R8 nack, R10 stickiness across commands
        run_cmd(2'b00, 8'h00, 1'b0);
        smode = 1; slave_ack = 1'b0;
        run_cmd(2'b10, 8'h3C, 1'b0);
        chk("R8 nack returned", int'(ack_out), 1);
        chk("R8 nack code", int'(err_code), 3);
        slave_ack = 1'b1;
        run_cmd(2'b10, 8'hC3, 1'b0);
        chk("R10 kept after good write", int'(err_code), 3);
        chk("R3 ack after good write", int'(ack_out), 0);
        clear_err();

        // R6 clock held low, later floating ack ignored
        smode = 0; force_scl = 1'b1;
        run_cmd(2'b10, 8'h00, 1'b0);
        chk("R6 clock low code", int'(err_code), 1);
        force_scl = 1'b0;
        clear_err();

        // R7 data held low on a one, then R10 later stop fault ignored
        force_sda = 1'b1;
        run_cmd(2'b10, 8'h80, 1'b0);
        chk("R7 data low code", int'(err_code), 2);
        run_cmd(2'b01, 8'h00, 1'b0);
        chk("R10 first fault kept", int'(err_code), 2);
        force_sda = 1'b0;
        clear_err();

        // R9 stop with data held low
        force_sda = 1'b1;
        run_cmd(2'b01, 8'h00, 1'b0);
        chk("R9 stop data code", int'(err_code), 4);
        force_sda = 1'b0;
        clear_err();

        // R11 command offered while busy is dropped
        run_cmd(2'b00, 8'h00, 1'b0);
        smode = 1; slave_ack = 1'b1;
        @(posedge clk); #1;
        fall_base = falls;
        d0 = done_cnt;
        cmd = 2'b10; wr_data = 8'hA5; cmd_valid = 1'b1;
        @(posedge clk); #1 cmd_valid = 1'b0;
        repeat (200) @(posedge clk);
        #1 cmd = 2'b11; wr_data = 8'h00; cmd_valid = 1'b1;
        @(posedge clk); #1 cmd_valid = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        chk("R11 original byte kept", int'(cap[8:1]), 8'hA5);
        repeat (60) @(negedge clk);
        chk("R11 dropped command never ran", int'(busy), 0);
        chk("R11 single completion", done_cnt - d0, 1);

        finish_run();
    end
endmodule